// File: doc/BRIEF.md
# Multi-Master Bus Arbitration Monitor

This block runs beside a master's transmit logic on a shared two-wire bus that uses open-drain, wired-AND signalling. It watches the resolved data line (SDA) and the synchronized clock line (SCL). From these it tracks START and STOP conditions and keeps a bus-busy flag. A new transfer may begin only when that flag is clear. The block also checks, for each transmitted bit, whether the level on the line matches the level this master meant to send.

Each bit is compared once, at a fixed sample point after the clock's rising-edge pulse, so that line transitions cannot cause false mismatches. A master that releases the line (sends HIGH) but reads LOW has been overridden by another master. The block then raises a sticky lost flag and forces its own data output to the released state for the rest of the transfer. Masters that send identical bit streams never lose, so several of them can complete the same transaction together. Clock generation, byte shifting, addressing and acknowledge handling belong to other blocks.

Top module: `mm_arb_monitor`

## Requirements
- R1: During and right after synchronous active-low reset, bus_busy is 0, bus_free is 1 and arb_lost is 0.
- R2: A START condition is `sda_line` falling (previous sample 1, present sample 0) while `scl_level` is 1. It sets `bus_busy` on the next clock, and `bus_free` always equals the inverse of `bus_busy`.
- R3: A STOP condition is `sda_line` rising (previous sample 0, present sample 1) while `scl_level` is 1. It clears `bus_busy` on the next clock.
- R4: `start_grant` is 1 in the same cycle exactly when `start_req` is 1 and `bus_busy` is 0. Two masters that request while the bus is free are both granted.
- R5: The line is compared only at the sample point, which falls SAMPLE_DELAY clocks after an `scl_rise` pulse. An `scl_fall` pulse at or before that point cancels it. A mismatch present at any other time has no effect.
- R6: If `tx_active` is 1, `sda_drive` is 1 and `sda_line` is 0 at a sample point, `arb_lost` becomes 1 on the next clock.
- R7: At a sample point where `sda_drive` is 0 or where `sda_line` equals `sda_drive`, `arb_lost` does not change. Identical bit streams therefore never lose.
- R8: With `tx_active` at 0, no mismatch sets `arb_lost`.
- R9: `arb_lost` stays 1 until a STOP condition or an `arb_clear` pulse, and it clears on the next clock. If a clear arrives in the same cycle as a mismatch, the clear wins.
- R10: `sda_out` (1 = release the line) is 1 while `arb_lost` is 1, and otherwise equals `sda_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_level | input | 1 | Synchronized SCL level |
| scl_rise | input | 1 | One-clock pulse on SCL rising edge |
| scl_fall | input | 1 | One-clock pulse on SCL falling edge |
| sda_line | input | 1 | Synchronized resolved SDA level |
| sda_drive | input | 1 | SDA level this master intends (1 = release) |
| tx_active | input | 1 | This master is transmitting |
| start_req | input | 1 | Request to begin a transfer |
| arb_clear | input | 1 | Pulse that clears the lost flag |
| start_grant | output | 1 | Permission to start this cycle |
| bus_busy | output | 1 | Bus held between START and STOP |
| bus_free | output | 1 | Inverse of bus_busy |
| arb_lost | output | 1 | Arbitration lost, sticky |
| sda_out | output | 1 | SDA level to drive (1 = release) |

## Verification
The bench builds the block with SAMPLE_DELAY at its default of 1, so each comparison lands one clock after the rising-edge pulse. With that setting the cycle in which a loss first appears can be predicted exactly. An `scl_fall` pulse in the sample cycle itself exercises the cancel path, and a clear that meets a mismatch in the same cycle exercises the priority between them. Data changes happen only while SCL is low, and a STOP is made on purpose with SCL high, so the bus-condition detector sees only the START and STOP events the bench intends.

// File: rtl/arb_mon_pkg.sv
// Shared types for the arbitration monitor.
package arb_mon_pkg;
    // Bus condition events detected on one system clock.
    typedef struct packed {
        logic start_evt;
        logic stop_evt;
    } bus_evt_t;
endpackage

// File: rtl/arb_bus_cond.sv
// Detects START and STOP on the two-wire bus and keeps the busy flag.
// Assumes sda_line and scl_level are already synchronized to clk.
module arb_bus_cond
    import arb_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_level,
    input  logic     sda_line,
    output bus_evt_t evt,
    output logic     bus_busy
);
    logic sda_prev;

    // Remember last SDA sample to find edges.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_line;
    end

    // Classify SDA edges seen while SCL is high.
    always_comb begin
        evt.start_evt = scl_level &  sda_prev & ~sda_line;
        evt.stop_evt  = scl_level & ~sda_prev &  sda_line;
    end

    // Busy flag: set by START, cleared by STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)             bus_busy <= 1'b0;
        else if (evt.start_evt) bus_busy <= 1'b1;
        else if (evt.stop_evt)  bus_busy <= 1'b0;
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_level && sda_prev && !sda_line) |=> bus_busy);
    assert_stop_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_level && !sda_prev && sda_line) |=> !bus_busy);
endmodule

// File: rtl/arb_sample_point.sv
// Produces one sample pulse SAMPLE_DELAY clocks after an SCL rise pulse.
// An SCL fall pulse at or before the sample point cancels it.
module arb_sample_point #(
    parameter int SAMPLE_DELAY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise,
    input  logic scl_fall,
    output logic sample
);
    localparam int LAST = SAMPLE_DELAY - 1;
    logic [LAST:0] dly;

    generate
        if (SAMPLE_DELAY == 1) begin : g_single
            // Single-stage delay of the rise pulse.
            always_ff @(posedge clk) begin
                if (!rst_n || scl_fall) dly <= '0;
                else                    dly <= scl_rise;
            end
        end else begin : g_chain
            // Multi-stage delay line of the rise pulse.
            always_ff @(posedge clk) begin
                if (!rst_n || scl_fall) dly <= '0;
                else                    dly <= {dly[LAST-1:0], scl_rise};
            end
        end
    endgenerate

    // Suppress a sample that coincides with a falling clock edge.
    assign sample = dly[LAST] & ~scl_fall;
endmodule

// File: rtl/arb_loss_track.sv
// Compares intended and resolved SDA at the sample point and keeps a
// sticky lost flag. Assumes a wired-AND line: only HIGH-sent, LOW-seen loses.
module arb_loss_track (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic tx_active,
    input  logic sda_drive,
    input  logic sda_line,
    input  logic stop_evt,
    input  logic arb_clear,
    output logic arb_lost
);
    logic mismatch;

    // Line overridden by another master at the sample point.
    assign mismatch = sample & tx_active & sda_drive & ~sda_line;

    // Sticky lost flag; clearing has priority over setting.
    always_ff @(posedge clk) begin
        if (!rst_n)                    arb_lost <= 1'b0;
        else if (stop_evt || arb_clear) arb_lost <= 1'b0;
        else if (mismatch)             arb_lost <= 1'b1;
    end

    assert_loss_at_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> $past(sample) && $past(tx_active));
    assert_low_never_loses_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !arb_lost && (!sda_drive || sda_line)) |=> !arb_lost);
    assert_idle_no_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && !arb_lost) |=> !arb_lost);
    assert_hold_until_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arb_lost) |-> $past(stop_evt || arb_clear));
endmodule

// File: rtl/mm_arb_monitor.sv
// Multi-master arbitration monitor: bus busy tracking, start permission,
// per-bit ownership check and forced SDA release on loss.
// Assumes all bus inputs are synchronized and edge pulses last one clock.
module mm_arb_monitor
    import arb_mon_pkg::*;
#(
    parameter int SAMPLE_DELAY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_level,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic sda_line,
    input  logic sda_drive,
    input  logic tx_active,
    input  logic start_req,
    input  logic arb_clear,
    output logic start_grant,
    output logic bus_busy,
    output logic bus_free,
    output logic arb_lost,
    output logic sda_out
);
    bus_evt_t evt;
    logic     sample;

    arb_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_level (scl_level),
        .sda_line  (sda_line),
        .evt       (evt),
        .bus_busy  (bus_busy)
    );

    arb_sample_point #(.SAMPLE_DELAY(SAMPLE_DELAY)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sample   (sample)
    );

    arb_loss_track u_loss (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sample),
        .tx_active (tx_active),
        .sda_drive (sda_drive),
        .sda_line  (sda_line),
        .stop_evt  (evt.stop_evt),
        .arb_clear (arb_clear),
        .arb_lost  (arb_lost)
    );

    // Outputs derived from busy and lost state.
    always_comb begin
        bus_free    = ~bus_busy;
        start_grant = start_req & ~bus_busy;
        sda_out     = arb_lost | sda_drive;
    end

    assert_release_on_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> sda_out);
endmodule

// File: tb/test_mm_arb_monitor.sv
module test_mm_arb_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_level = 1'b1, scl_rise = 1'b0, scl_fall = 1'b0;
    logic sda_line = 1'b1, sda_drive = 1'b1, tx_active = 1'b0;
    logic start_req = 1'b0, arb_clear = 1'b0;
    logic start_grant, bus_busy, bus_free, arb_lost, sda_out;
    int   n_checks = 0, n_fails = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mm_arb_monitor i_mm_arb_monitor (
        .clk(clk), .rst_n(rst_n), .scl_level(scl_level), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .sda_line(sda_line), .sda_drive(sda_drive),
        .tx_active(tx_active), .start_req(start_req), .arb_clear(arb_clear),
        .start_grant(start_grant), .bus_busy(bus_busy), .bus_free(bus_free),
        .arb_lost(arb_lost), .sda_out(sda_out)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // One data bit: SDA changes with SCL low, then SCL rises; returns once the
    // sample result is visible. clr_s / fall_s act in the sample cycle.
    task automatic send_bit(input logic drv, input logic line, input logic clr_s, input logic fall_s);
        scl_level = 1'b0; scl_fall = 1'b1; sda_drive = drv; sda_line = line;
        tick(1); scl_fall = 1'b0;
        tick(1); scl_level = 1'b1; scl_rise = 1'b1;
        tick(1); scl_rise = 1'b0; arb_clear = clr_s; scl_fall = fall_s;
        if (fall_s) scl_level = 1'b0;
        tick(1); arb_clear = 1'b0; scl_fall = 1'b0;
    endtask

    task automatic do_start();
        scl_level = 1'b1; sda_line = 1'b1; tick(1);
        sda_line = 1'b0; tick(1);
    endtask

    task automatic do_stop();
        scl_level = 1'b0; sda_line = 1'b0; sda_drive = 1'b1; tick(1);
        scl_level = 1'b1; tick(1);
        sda_line = 1'b1; tick(1);
    endtask

    task automatic t_reset();
        tick(2);
        check("R1", "busy in reset", bus_busy, 1'b0);
        check("R1", "free in reset", bus_free, 1'b1);
        check("R1", "lost in reset", arb_lost, 1'b0);
        rst_n = 1'b1; tick(1);
        check("R1", "busy after reset", bus_busy, 1'b0);
    endtask

    task automatic t_grant_and_start();
        start_req = 1'b1; #1;
        check("R4", "grant on free bus", start_grant, 1'b1);
        do_start();
        start_req = 1'b1; #1;
        check("R2", "busy after START", bus_busy, 1'b1);
        check("R2", "free low after START", bus_free, 1'b0);
        check("R4", "grant refused when busy", start_grant, 1'b0);
        start_req = 1'b0;
    endtask

    task automatic t_identical_streams();
        tx_active = 1'b1;
        send_bit(1'b1, 1'b1, 1'b0, 1'b0);
        send_bit(1'b0, 1'b0, 1'b0, 1'b0);
        send_bit(1'b1, 1'b1, 1'b0, 1'b0);
        check("R7", "matching bits keep ownership", arb_lost, 1'b0);
        send_bit(1'b0, 1'b0, 1'b0, 1'b0);
        check("R10", "sda_out follows drive", sda_out, 1'b0);
    endtask

    task automatic t_off_sample();
        scl_level = 1'b0; sda_drive = 1'b1; sda_line = 1'b0; tick(5);
        check("R5", "mismatch without sample point ignored", arb_lost, 1'b0);
        send_bit(1'b1, 1'b0, 1'b0, 1'b1);
        check("R5", "fall pulse cancels sample", arb_lost, 1'b0);
    endtask

    task automatic t_idle_no_check();
        tx_active = 1'b0;
        send_bit(1'b1, 1'b0, 1'b0, 1'b0);
        check("R8", "no loss when not transmitting", arb_lost, 1'b0);
        tx_active = 1'b1;
    endtask

    task automatic t_clear_priority();
        send_bit(1'b1, 1'b0, 1'b1, 1'b0);
        check("R9", "clear wins over mismatch", arb_lost, 1'b0);
    endtask

    task automatic t_loss_and_clear();
        send_bit(1'b1, 1'b0, 1'b0, 1'b0);
        check("R6", "loss on HIGH-sent LOW-seen", arb_lost, 1'b1);
        sda_drive = 1'b0; #1;
        check("R10", "SDA released while lost", sda_out, 1'b1);
        send_bit(1'b1, 1'b1, 1'b0, 1'b0);
        check("R9", "lost flag held", arb_lost, 1'b1);
        arb_clear = 1'b1; tick(1); arb_clear = 1'b0;
        check("R9", "cleared by arb_clear", arb_lost, 1'b0);
    endtask

    task automatic t_loss_then_stop();
        send_bit(1'b1, 1'b0, 1'b0, 1'b0);
        check("R6", "second loss", arb_lost, 1'b1);
        do_stop();
        check("R9", "STOP clears lost", arb_lost, 1'b0);
        check("R3", "STOP clears busy", bus_busy, 1'b0);
        check("R2", "free after STOP", bus_free, 1'b1);
        start_req = 1'b1; #1;
        check("R4", "grant after STOP", start_grant, 1'b1);
        start_req = 1'b0;
    endtask

    initial begin
        t_reset();
        t_grant_and_start();
        t_identical_streams();
        t_off_sample();
        t_idle_no_check();
        t_clear_priority();
        t_loss_and_clear();
        t_loss_then_stop();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule